// File: doc/BRIEF.md
# OQPSK Carrier Phase Recovery Loop

This block removes an unknown carrier phase from an offset-QPSK signal with a discrete-time phase-locked loop. Complex baseband samples arrive two per symbol, each marked by a valid strobe. The sample with even index carries the inphase decision point. The sample with odd index carries the quadrature decision point, half a symbol later. Each sample is rotated back by the current estimate of the phase. A commutator pairs each even sample with the odd sample that follows it. The block emits one de-rotated inphase/quadrature pair per symbol.

The phase detector works on that symbol-rate pair. Its error is zero-stuffed back to the sample rate. A proportional-plus-integral filter then steers a 16-bit phase accumulator. The top bits of that accumulator address a sine/cosine table. The loop settles with a two-fold phase ambiguity, and it does not tell which stream holds true I and which holds the delayed Q. A later differential decoder resolves both of these.

Top module: `oqpsk_phase_loop`

## Requirements
- R1: A synchronous active-low reset clears the phase accumulator, the integrator, the sample parity, the stored error and the symbol outputs. After reset, sym_valid, sym_i and sym_q are 0.
- R2: The table index is the top 8 bits of the 16-bit phase accumulator. The entry at index k is round(2047·cos(2πk/256)) for cosine and round(2047·sin(2πk/256)) for sine, rounded to the nearest integer.
- R3: Each sample x is rotated by the conjugate of the table phasor. yi = (xi·c + xq·s) >>> 11 and yq = (xq·c − xi·s) >>> 11, where >>> is a floor shift. The results are 13-bit signed values.
- R4: The first valid sample after reset has even parity, and parity then alternates. On an odd sample, sym_i takes yi of the preceding even sample and sym_q takes yq of the odd sample. sym_valid is a one-cycle pulse in the clock after the odd sample is taken.
- R5: While in_valid is low, no state changes. sym_valid stays low, and sym_i and sym_q hold their values.
- R6: On each odd sample the detector forms e = s(I)·Q − s(Q)·I. Here I is the paired even-sample yi, Q is the odd-sample yq, and s(v) is +1 for v ≥ 0 and −1 otherwise.
- R7: The loop filter runs on every valid sample. Its input u equals the last stored e on even samples and 0 on odd samples, so each error is followed by one inserted zero. Before the first error, u is 0.
- R8: On each valid sample, the phase advances by the low 16 bits of (k_prop·u + integ) >>> 8, using the integrator value from before the update. The integrator, 24 bits wide and wrapping, then adds k_int·u. The sample itself is rotated with the phase from before this update.
- R9: With k_prop = k_int = 0 the phase stays 0. Each output then equals its input component scaled by 2047/2048 and floored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks a valid input sample |
| in_i | input | 12 | Inphase input sample, signed |
| in_q | input | 12 | Quadrature input sample, signed |
| k_prop | input | 8 | Proportional gain, signed |
| k_int | input | 8 | Integral gain, signed |
| sym_valid | output | 1 | Marks a new output symbol pair |
| sym_i | output | 13 | De-rotated inphase symbol, signed |
| sym_q | output | 13 | De-rotated quadrature symbol, signed |

## Verification
The first pattern drives fixed samples with zero gains. The result is predicted by hand, which isolates the table entry at index 0 and the floor shift from the loop. Two loop runs use random offset-QPSK data. One has a static phase offset and frequency gaps in the valid strobe. The other has a drifting phase and larger gains. A bit-exact model in the bench predicts every symbol for both runs, so errors in the detector sign, the zero insertion, the gain scaling, the table or the pairing show up as a mismatch. Two further sequences are checked. A stall between the two halves of a symbol tests that the outputs hold. A reset after an odd number of samples tests that the parity restarts.

// File: rtl/oqpsk_loop_pkg.sv
// Package: shared helpers for the OQPSK phase loop.
// Assumes: table contents are computed once, at elaboration.
package oqpsk_loop_pkg;

    // Rounded trigonometric table entry; sel_sin picks sine over cosine.
    function automatic int trig_entry(input int idx, input int depth,
                                      input int amp, input bit sel_sin);
        real ang;
        real val;
        ang = 2.0 * 3.14159265358979323846 * real'(idx) / real'(depth);
        val = real'(amp) * (sel_sin ? $sin(ang) : $cos(ang));
        if (val >= 0.0) return $rtoi(val + 0.5);
        else            return -$rtoi(0.5 - val);
    endfunction

endpackage

// File: rtl/oqpsk_derotator.sv
// Module: de-rotates one complex sample by the conjugate of a table phasor.
// Assumes: purely combinational. The caller registers the result.
// The output width is wide enough for the largest rotated magnitude.
module oqpsk_derotator #(
    parameter int IN_W   = 12,
    parameter int LUT_AW = 8,
    parameter int LUT_W  = 12,
    parameter int OUT_W  = 13
) (
    input  logic signed [IN_W-1:0]  x_i,
    input  logic signed [IN_W-1:0]  x_q,
    input  logic        [LUT_AW-1:0] idx,
    output logic signed [OUT_W-1:0] y_i,
    output logic signed [OUT_W-1:0] y_q
);
    import oqpsk_loop_pkg::*;

    localparam int LUT_D = 1 << LUT_AW;
    localparam int AMP   = (1 << (LUT_W - 1)) - 1;
    localparam int PW    = IN_W + LUT_W;

    logic signed [LUT_W-1:0] cos_tab [LUT_D];
    logic signed [LUT_W-1:0] sin_tab [LUT_D];

    // One constant cosine and sine entry per table address.
    for (genvar g = 0; g < LUT_D; g++) begin : g_tab
        localparam int CV = trig_entry(g, LUT_D, AMP, 1'b0);
        localparam int SV = trig_entry(g, LUT_D, AMP, 1'b1);
        assign cos_tab[g] = LUT_W'(CV);
        assign sin_tab[g] = LUT_W'(SV);
    end

    logic signed [LUT_W-1:0] c_v, s_v;
    logic signed [PW-1:0]    p_ic, p_qs, p_qc, p_is;
    logic signed [PW:0]      acc_i, acc_q;

    // Complex multiply by (c - js), then a floor shift back to sample scale.
    always_comb begin
        c_v   = cos_tab[idx];
        s_v   = sin_tab[idx];
        p_ic  = PW'(x_i) * PW'(c_v);
        p_qs  = PW'(x_q) * PW'(s_v);
        p_qc  = PW'(x_q) * PW'(c_v);
        p_is  = PW'(x_i) * PW'(s_v);
        acc_i = (PW+1)'(p_ic) + (PW+1)'(p_qs);
        acc_q = (PW+1)'(p_qc) - (PW+1)'(p_is);
        y_i   = OUT_W'(acc_i >>> (LUT_W - 1));
        y_q   = OUT_W'(acc_q >>> (LUT_W - 1));
    end
endmodule

// File: rtl/oqpsk_pair_detector.sv
// Module: commutator and decision-directed phase error detector.
// Assumes: even samples carry I and odd samples carry the delayed Q.
// The even value is held one sample so that it lines up with its odd partner.
module oqpsk_pair_detector #(
    parameter int OUT_W = 13,
    parameter int ERR_W = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [OUT_W-1:0] y_i,
    input  logic signed [OUT_W-1:0] y_q,
    output logic                    odd_ph,
    output logic                    sym_valid,
    output logic signed [OUT_W-1:0] sym_i,
    output logic signed [OUT_W-1:0] sym_q,
    output logic signed [ERR_W-1:0] err
);
    logic signed [OUT_W-1:0] hold_i;
    logic signed [ERR_W-1:0] q_ext, i_ext, term_a, term_b, err_n;

    // Error from the held I and the current Q, using decision signs.
    always_comb begin
        q_ext  = ERR_W'(y_q);
        i_ext  = ERR_W'(hold_i);
        term_a = hold_i[OUT_W-1] ? -q_ext : q_ext;
        term_b = y_q[OUT_W-1]    ? -i_ext : i_ext;
        err_n  = term_a - term_b;
    end

    // Parity toggle, even-sample hold, and symbol and error capture on odd samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_ph    <= 1'b0;
            hold_i    <= '0;
            sym_valid <= 1'b0;
            sym_i     <= '0;
            sym_q     <= '0;
            err       <= '0;
        end else begin
            sym_valid <= in_valid && odd_ph;
            if (in_valid) begin
                odd_ph <= ~odd_ph;
                if (!odd_ph) begin
                    hold_i <= y_i;
                end else begin
                    sym_i <= hold_i;
                    sym_q <= y_q;
                    err   <= err_n;
                end
            end
        end
    end
endmodule

// File: rtl/oqpsk_pi_nco.sv
// Module: zero-stuffing, proportional-plus-integral filter and phase accumulator.
// Assumes: it runs once per valid sample. The error is consumed on even
// samples and replaced by zero on odd ones. INT_W >= K_W + ERR_W.
module oqpsk_pi_nco #(
    parameter int ERR_W      = 15,
    parameter int K_W        = 8,
    parameter int INT_W      = 24,
    parameter int PH_W       = 16,
    parameter int GAIN_SHIFT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    odd_ph,
    input  logic signed [ERR_W-1:0] err,
    input  logic signed [K_W-1:0]   k_prop,
    input  logic signed [K_W-1:0]   k_int,
    output logic        [PH_W-1:0]  phase
);
    localparam int PRW = K_W + ERR_W;

    logic signed [ERR_W-1:0] u;
    logic signed [PRW-1:0]   prop, intg_in;
    logic signed [INT_W:0]   ctrl;
    logic signed [INT_W-1:0] integ;
    logic        [PH_W-1:0]  step;

    // Zero insertion, both gain products and the scaled phase step.
    always_comb begin
        u       = odd_ph ? '0 : err;
        prop    = PRW'(k_prop) * PRW'(u);
        intg_in = PRW'(k_int) * PRW'(u);
        ctrl    = (INT_W+1)'(prop) + (INT_W+1)'(integ);
        step    = PH_W'(ctrl >>> GAIN_SHIFT);
    end

    // Integrator and phase accumulator, both wrapping, advanced per valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ <= '0;
            phase <= '0;
        end else if (in_valid) begin
            integ <= integ + INT_W'(intg_in);
            phase <= phase + step;
        end
    end
endmodule

// File: rtl/oqpsk_phase_loop.sv
// Module: top level of the OQPSK carrier phase recovery loop.
// Assumes: two samples per symbol, marked by in_valid. The first sample
// after reset has even parity. Gains change only while the loop is idle.
module oqpsk_phase_loop #(
    parameter int IN_W       = 12,
    parameter int K_W        = 8,
    parameter int PH_W       = 16,
    parameter int LUT_AW     = 8,
    parameter int LUT_W      = 12,
    parameter int INT_W      = 24,
    parameter int GAIN_SHIFT = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_i,
    input  logic signed [IN_W-1:0] in_q,
    input  logic signed [K_W-1:0]  k_prop,
    input  logic signed [K_W-1:0]  k_int,
    output logic                   sym_valid,
    output logic signed [IN_W:0]   sym_i,
    output logic signed [IN_W:0]   sym_q
);
    localparam int OUT_W = IN_W + 1;
    localparam int ERR_W = OUT_W + 2;

    logic signed [OUT_W-1:0] rot_i, rot_q;
    logic signed [ERR_W-1:0] err;
    logic                    odd_ph;
    logic        [PH_W-1:0]  phase;

    oqpsk_derotator #(
        .IN_W(IN_W), .LUT_AW(LUT_AW), .LUT_W(LUT_W), .OUT_W(OUT_W)
    ) u_rot (
        .x_i(in_i), .x_q(in_q), .idx(phase[PH_W-1 -: LUT_AW]),
        .y_i(rot_i), .y_q(rot_q)
    );

    oqpsk_pair_detector #(
        .OUT_W(OUT_W), .ERR_W(ERR_W)
    ) u_ped (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .y_i(rot_i), .y_q(rot_q), .odd_ph(odd_ph),
        .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q), .err(err)
    );

    oqpsk_pi_nco #(
        .ERR_W(ERR_W), .K_W(K_W), .INT_W(INT_W), .PH_W(PH_W),
        .GAIN_SHIFT(GAIN_SHIFT)
    ) u_nco (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .odd_ph(odd_ph),
        .err(err), .k_prop(k_prop), .k_int(k_int), .phase(phase)
    );
endmodule

// File: rtl/oqpsk_phase_loop_chk.sv
// Module: property checker for the phase loop, attached by bind.
// Assumes: it sees the ports and the internal phase accumulator.
module oqpsk_phase_loop_chk #(
    parameter int OUT_W = 13,
    parameter int PH_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    sym_valid,
    input logic signed [OUT_W-1:0] sym_i,
    input logic signed [OUT_W-1:0] sym_q,
    input logic        [PH_W-1:0]  phase
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!sym_valid && sym_i == '0 && sym_q == '0 && phase == '0));

    // R4
    sym_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid);

    // R4
    sym_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> $past(in_valid));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!sym_valid && $stable(sym_i) && $stable(sym_q)));

    // R8
    phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(phase));
endmodule

bind oqpsk_phase_loop oqpsk_phase_loop_chk #(
    .OUT_W(IN_W + 1), .PH_W(PH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sym_valid(sym_valid),
    .sym_i(sym_i), .sym_q(sym_q), .phase(phase)
);

// File: tb/oqpsk_phase_loop_tb.sv
// Bench: a scoreboard for the phase loop. The driver runs a bit-exact model
// of the requirements and queues the expected symbols. The monitor pops and
// compares them whenever sym_valid is seen.
module oqpsk_phase_loop_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [11:0] in_i = '0, in_q = '0;
    logic signed [7:0]  k_prop = '0, k_int = '0;
    logic sym_valid;
    logic signed [12:0] sym_i, sym_q;

    int checks = 0;
    int errors = 0;
    int exp_i_q[$];
    int exp_q_q[$];

    // model state
    longint m_ph, m_int, m_err, m_hold;
    bit     m_odd;

    always #4 clk = ~clk; // 125 MHz

    oqpsk_phase_loop u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .k_prop(k_prop), .k_int(k_int), .sym_valid(sym_valid),
        .sym_i(sym_i), .sym_q(sym_q)
    );

    function automatic longint sx(input longint v, input int w);
        longint m;
        m = v & ((longint'(1) << w) - 1);
        if (m >= (longint'(1) << (w - 1))) m = m - (longint'(1) << w);
        return m;
    endfunction

    function automatic int rnd(input real r);
        if (r >= 0.0) return $rtoi(r + 0.5);
        else          return -$rtoi(0.5 - r);
    endfunction

    // R2 table entries
    function automatic longint tab(input longint k, input bit want_sin);
        real a;
        a = 2.0 * 3.14159265358979323846 * real'(k) / 256.0;
        return longint'(rnd(2047.0 * (want_sin ? $sin(a) : $cos(a))));
    endfunction

    task automatic check(input bit ok, input string what, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_int = 0; m_err = 0; m_hold = 0; m_odd = 1'b0;
        exp_i_q.delete();
        exp_q_q.delete();
    endtask

    // One model step per valid sample: R3 rotation, R4 pairing, R6 error,
    // R7 zero insertion, R8 loop update.
    task automatic model_step(input longint xi, input longint xq);
        longint c, s, yi, yq, u, ta, tb;
        c  = tab(m_ph >> 8, 1'b0);
        s  = tab(m_ph >> 8, 1'b1);
        yi = sx((xi * c + xq * s) >>> 11, 13);
        yq = sx((xq * c - xi * s) >>> 11, 13);
        if (!m_odd) begin
            u = m_err;
            m_hold = yi;
        end else begin
            u = 0;
            ta = (m_hold >= 0) ? yq : -yq;
            tb = (yq >= 0) ? m_hold : -m_hold;
            m_err = ta - tb;
            exp_i_q.push_back(int'(m_hold));
            exp_q_q.push_back(int'(yq));
        end
        m_ph  = (m_ph + ((longint'(k_prop) * u + m_int) >>> 8)) & 65535;
        m_int = sx(m_int + longint'(k_int) * u, 24);
        m_odd = ~m_odd;
    endtask

    task automatic drive(input int xi, input int xq);
        @(negedge clk);
        in_valid = 1'b1;
        in_i = 12'(xi);
        in_q = 12'(xq);
        model_step(longint'(xi), longint'(xq));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Random offset-QPSK stream rotated by a (possibly drifting) phase.
    task automatic run_stream(input int nsym, input real ph0, input real drift, input bit gaps);
        int a, b_prev, b;
        real ph, vi, vq;
        b_prev = 1;
        ph = ph0;
        for (int k = 0; k < nsym; k++) begin
            a = $urandom_range(0, 1) ? 1 : -1;
            b = $urandom_range(0, 1) ? 1 : -1;
            for (int h = 0; h < 2; h++) begin
                vi = 1400.0 * a;
                vq = 1400.0 * (h == 0 ? b_prev : b);
                drive(rnd(vi * $cos(ph) - vq * $sin(ph)), rnd(vi * $sin(ph) + vq * $cos(ph)));
                ph = ph + drift;
                if (gaps && $urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
            end
            b_prev = b;
        end
        idle(4);
    endtask

    // Monitor: compare each produced symbol with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && sym_valid) begin
            if (exp_i_q.size() == 0) begin
                check(1'b0, "R4 unexpected symbol, queue empty", 1, 0);
            end else begin
                int ei, eq;
                ei = exp_i_q.pop_front();
                eq = exp_q_q.pop_front();
                check(int'(sym_i) == ei, "R2/R3/R4/R6/R7/R8 sym_i", longint'(sym_i), longint'(ei));
                check(int'(sym_q) == eq, "R2/R3/R4/R6/R7/R8 sym_q", longint'(sym_q), longint'(eq));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!sym_valid, "R1 sym_valid after reset", longint'(sym_valid), 0);
        check(sym_i == 0, "R1 sym_i after reset", longint'(sym_i), 0);
        check(sym_q == 0, "R1 sym_q after reset", longint'(sym_q), 0);

        // R9 zero gains: index 0, scale 2047/2048 floored
        drive(1000, -600);
        drive(-500, 800);
        idle(1);
        check(sym_valid, "R4 pulse after odd sample", longint'(sym_valid), 1);
        check(sym_i == 999, "R9 sym_i zero-gain", longint'(sym_i), 999);
        check(sym_q == 799, "R9 sym_q zero-gain", longint'(sym_q), 799);
        idle(1);
        check(!sym_valid, "R4 pulse lasts one cycle", longint'(sym_valid), 0);

        // R5 stall between the two halves of a symbol
        drive(-1200, 300);
        for (int k = 0; k < 4; k++) begin
            idle(1);
            check(!sym_valid, "R5 no symbol while idle", longint'(sym_valid), 0);
            check(sym_i == 999, "R5 sym_i held while idle", longint'(sym_i), 999);
        end
        drive(700, -900);
        idle(3);

        // R1 reset after an odd number of samples restarts the parity
        drive(400, 400);
        drive(-400, 400);
        drive(900, -100);
        do_reset();
        check(!sym_valid && sym_i == 0 && sym_q == 0, "R1 outputs cleared mid-stream",
              longint'(sym_i), 0);
        drive(-800, 200);
        idle(1);
        check(!sym_valid, "R4 first sample after reset is even", longint'(sym_valid), 0);
        drive(100, -1500);
        idle(3);

        // Loop run 1: static 30 degree offset, gaps in the valid strobe
        do_reset();
        k_prop = 8'sd64;
        k_int  = 8'sd1;
        run_stream(400, 0.5236, 0.0, 1'b1);

        // Loop run 2: drifting phase, larger gains
        do_reset();
        k_prop = 8'sd96;
        k_int  = 8'sd4;
        run_stream(300, -1.7453, 0.002, 1'b0);

        idle(4);
        check(exp_i_q.size() == 0, "R4 every odd sample produced a symbol",
              longint'(exp_i_q.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule